// File: doc/BRIEF.md
# Lamp Fault Supervisor

This block watches a set of lamp channels (two by default) for four kinds of fault: open lamp, lamp overcurrent, failure to strike and overvoltage. The detect inputs are digital pulses that have already been qualified upstream. Any detect pulse sets a fault bit for its channel, and that bit stays set. A configuration bit chooses how far a fault reaches. It can turn off only the channel that faulted, or it can turn off every channel. A single shared fault output shows that some channel holds a fault.

A host clear pulse removes the stored faults. When retry is enabled, each channel can also clear itself. It waits a set number of dimming periods, then re-enables the channel so the lamp gets another strike. An overcurrent fault never takes this retry path. A channel also stops retrying after a set number of attempts, and after that only the host clear releases it. Live status bits copy the detect inputs one cycle later, whatever the stored state is.

Top module: `lamp_fault_supervisor`

## Requirements
- R1: During and right after synchronous reset: every stored fault bit is 0, every live status bit is 0, `fault_o` is 0 and every `ch_en` bit is 1.
- R2: `live_stat[4*c+k]` equals detect input k of channel c as sampled at the previous clock edge, whether or not that fault is stored. Type order is k=0 open, k=1 overcurrent, k=2 strike failure, k=3 overvoltage.
- R3: A detect input that is high at a clock edge sets `latch_stat[4*c+k]` at that edge. The bit then holds until a host clear or a retry removes it.
- R4: With `cfg_global`=0, `ch_en[c]` goes to 0 one cycle after any bit of channel c is stored. The other channels stay enabled.
- R5: With `cfg_global`=1, every `ch_en` bit goes to 0 one cycle after any channel stores a fault.
- R6: `fault_o` is the OR of all stored bits, delayed by one register. It rises in the cycle after the first bit is stored and falls in the cycle after the last bit is cleared.
- R7: A `host_clr` pulse clears every stored bit and every retry attempt count. The exception is a bit whose detect input is high in that same cycle: that bit stays set.
- R8: With `cfg_retry`=1, a faulted channel that holds no overcurrent bit clears its stored bits on the RETRY_WAIT-th (default 4) `dim_tick` pulse counted while it is faulted.
- R9: A channel holding a stored overcurrent bit is never cleared by retry, however many `dim_tick` pulses arrive.
- R10: After MAX_TRIES (default 8) retry clears, a channel makes no further retries until `host_clr`.
- R11: With `cfg_retry`=0, `dim_tick` pulses leave the stored bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_clr | input | 1 | Host pulse that clears stored faults |
| cfg_global | input | 1 | 1: any fault disables every channel; 0: only the faulting channel |
| cfg_retry | input | 1 | 1: enable automatic retry by re-strike |
| dim_tick | input | 1 | One-cycle pulse per dimming period |
| det_open | input | NCH | Open-lamp detect, one bit per channel |
| det_ocur | input | NCH | Lamp overcurrent detect |
| det_nostrike | input | NCH | Strike failure detect |
| det_ovolt | input | NCH | Overvoltage detect |
| ch_en | output | NCH | Channel enable, registered |
| fault_o | output | 1 | Shared fault indicator, registered |
| live_stat | output | 4*NCH | Registered copy of the detect inputs |
| latch_stat | output | 4*NCH | Stored fault bits, index 4*channel+type |

## Verification
The bench aims at the cycle boundaries of the retry path. It checks that a channel is still faulted after RETRY_WAIT-1 ticks and clear after the last one. A counter that is off by one would release the lamp one dimming period early or late. It holds a detect input high across a host clear, and a design that lets the clear win would drop a fault that is still present. It runs the ninth fault after eight retries, where a design that never stops retrying would re-strike forever. It also runs an overcurrent fault with retry enabled, which must stay stored. Finally it samples `fault_o` and `ch_en` one cycle apart from the stored bits, to catch a wrong pipeline depth and a wrong shutdown scope.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  localparam int NFT       = 4;
  localparam int FT_OPEN   = 0;
  localparam int FT_OCUR   = 1;
  localparam int FT_STRIKE = 2;
  localparam int FT_OVOLT  = 3;
  typedef logic [NFT-1:0] fvec_t;
endpackage

// File: rtl/lfs_fault_latch.sv
module lfs_fault_latch
  import lfs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  host_clr,
  input  logic  retry_clr,
  input  fvec_t det,
  output fvec_t q
);
  fvec_t clr_mask;

  always_comb begin
    clr_mask = '0;
    if (host_clr) begin
      clr_mask = '1;
    end else if (retry_clr) begin
      clr_mask = '1;
      clr_mask[FT_OCUR] = 1'b0;
    end
  end

  // a set always wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= det | (q & ~clr_mask);
  end

  // R3: stored bits hold while nothing clears them
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!host_clr && !retry_clr) |=> ((q & $past(q)) == $past(q)));

  // R9: only the host clear removes a stored overcurrent bit
  a_r9_ocur_sticky: assert property (@(posedge clk) disable iff (rst)
    (q[FT_OCUR] && !host_clr) |=> q[FT_OCUR]);

  // R7: a detect that is active during a host clear stays stored
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    (host_clr && det != '0) |=> ((q & $past(det)) == $past(det)));
endmodule

// File: rtl/lfs_retry_ctl.sv
module lfs_retry_ctl #(
  parameter int RETRY_WAIT = 4,
  parameter int MAX_TRIES  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic host_clr,
  input  logic cfg_retry,
  input  logic dim_tick,
  input  logic faulted,
  input  logic ocur_held,
  output logic retry_clr
);
  localparam int WAIT_W = $clog2(RETRY_WAIT + 1);
  localparam int TRY_W  = $clog2(MAX_TRIES + 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(RETRY_WAIT - 1);
  localparam logic [TRY_W-1:0]  TRY_CAP   = TRY_W'(MAX_TRIES);

  logic [WAIT_W-1:0] wait_cnt;
  logic [TRY_W-1:0]  tries;
  logic              eligible;

  assign eligible  = cfg_retry && faulted && !ocur_held && (tries < TRY_CAP);
  assign retry_clr = eligible && dim_tick && (wait_cnt == WAIT_LAST);

  always_ff @(posedge clk) begin
    if (rst || host_clr) begin
      wait_cnt <= '0;
      tries    <= '0;
    end else if (!eligible) begin
      wait_cnt <= '0;
    end else if (dim_tick) begin
      if (wait_cnt == WAIT_LAST) begin
        wait_cnt <= '0;
        tries    <= tries + 1'b1;
      end else begin
        wait_cnt <= wait_cnt + 1'b1;
      end
    end
  end

  // R10: once the attempt budget is spent no retry fires until a host clear
  a_r10_budget: assert property (@(posedge clk) disable iff (rst)
    (tries == TRY_CAP && !host_clr) |=> (!retry_clr && tries == TRY_CAP));

  // R8: a retry only ever follows a dimming tick with retry enabled
  a_r8_tick_gate: assert property (@(posedge clk) disable iff (rst)
    retry_clr |-> (dim_tick && cfg_retry));
endmodule

// File: rtl/lamp_fault_supervisor.sv
module lamp_fault_supervisor
  import lfs_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int RETRY_WAIT = 4,
  parameter int MAX_TRIES  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_clr,
  input  logic             cfg_global,
  input  logic             cfg_retry,
  input  logic             dim_tick,
  input  logic [NCH-1:0]   det_open,
  input  logic [NCH-1:0]   det_ocur,
  input  logic [NCH-1:0]   det_nostrike,
  input  logic [NCH-1:0]   det_ovolt,
  output logic [NCH-1:0]   ch_en,
  output logic             fault_o,
  output logic [NFT*NCH-1:0] live_stat,
  output logic [NFT*NCH-1:0] latch_stat
);
  logic [NCH-1:0][NFT-1:0] det_all;
  logic [NCH-1:0][NFT-1:0] lat_q;
  logic [NCH-1:0]          ch_fault;
  logic [NCH-1:0]          retry_clr;
  logic [NCH-1:0]          en_next;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_comb begin
      det_all[c]            = '0;
      det_all[c][FT_OPEN]   = det_open[c];
      det_all[c][FT_OCUR]   = det_ocur[c];
      det_all[c][FT_STRIKE] = det_nostrike[c];
      det_all[c][FT_OVOLT]  = det_ovolt[c];
    end

    lfs_fault_latch i_latch (
      .clk       (clk),
      .rst       (rst),
      .host_clr  (host_clr),
      .retry_clr (retry_clr[c]),
      .det       (det_all[c]),
      .q         (lat_q[c])
    );

    assign ch_fault[c] = |lat_q[c];

    lfs_retry_ctl #(
      .RETRY_WAIT (RETRY_WAIT),
      .MAX_TRIES  (MAX_TRIES)
    ) i_retry (
      .clk       (clk),
      .rst       (rst),
      .host_clr  (host_clr),
      .cfg_retry (cfg_retry),
      .dim_tick  (dim_tick),
      .faulted   (ch_fault[c]),
      .ocur_held (lat_q[c][FT_OCUR]),
      .retry_clr (retry_clr[c])
    );

    assign en_next[c] = cfg_global ? ~(|ch_fault) : ~ch_fault[c];
  end

  assign latch_stat = lat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_stat <= '0;
      fault_o   <= 1'b0;
      ch_en     <= '1;
    end else begin
      live_stat <= det_all;
      fault_o   <= |ch_fault;
      ch_en     <= en_next;
    end
  end

  // R5: in global mode a raised fault output means every channel is off
  a_r5_global_off: assert property (@(posedge clk) disable iff (rst)
    (fault_o && $past(cfg_global)) |-> (ch_en == '0));

  // R4: with no fault reported every channel is enabled
  a_r4_idle_on: assert property (@(posedge clk) disable iff (rst)
    !fault_o |-> (ch_en == '1));

  // R6: the fault output trails the stored bits by one cycle
  a_r6_fault_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(|lat_q) |=> fault_o);
endmodule

// File: tb/test_lamp_fault_supervisor.sv
`timescale 1ns/1ps
module test_lamp_fault_supervisor;
  localparam int NCH = 2;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_clr = 1'b0, cfg_global = 1'b0, cfg_retry = 1'b0, dim_tick = 1'b0;
  logic [NCH-1:0] d_open = '0, d_ocur = '0, d_nostr = '0, d_ovolt = '0;
  logic [NCH-1:0] ch_en;
  logic fault_o;
  logic [4*NCH-1:0] live_stat, latch_stat;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lamp_fault_supervisor i_lamp_fault_supervisor (
    .clk(clk), .rst(rst), .host_clr(host_clr), .cfg_global(cfg_global),
    .cfg_retry(cfg_retry), .dim_tick(dim_tick), .det_open(d_open),
    .det_ocur(d_ocur), .det_nostrike(d_nostr), .det_ovolt(d_ovolt),
    .ch_en(ch_en), .fault_o(fault_o), .live_stat(live_stat),
    .latch_stat(latch_stat)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      dim_tick = 1'b1; step(); dim_tick = 1'b0; step();
    end
  endtask

  task automatic hclr();
    host_clr = 1'b1; step(); host_clr = 1'b0; step(2);
  endtask

  task automatic t_reset();
    step(2);
    check("R1 latch", latch_stat, 0);
    check("R1 live", live_stat, 0);
    check("R1 fault", fault_o, 0);
    check("R1 en", ch_en, 2'b11);
    rst = 1'b0; step();
    check("R1 en after release", ch_en, 2'b11);
  endtask

  task automatic t_local_and_clear();
    cfg_global = 1'b0;
    d_open[0] = 1'b1; step(); d_open[0] = 1'b0;
    check("R3 latch set", latch_stat, 8'h01);
    check("R2 live copy", live_stat, 8'h01);
    check("R6 fault not yet", fault_o, 0);
    step();
    check("R2 live drops", live_stat, 8'h00);
    check("R6 fault rises", fault_o, 1);
    check("R4 only ch0 off", ch_en, 2'b10);
    step(5);
    check("R3 latch holds", latch_stat, 8'h01);
    host_clr = 1'b1; step(); host_clr = 1'b0;
    check("R7 cleared", latch_stat, 8'h00);
    check("R6 fault lags clear", fault_o, 1);
    step();
    check("R6 fault falls", fault_o, 0);
    check("R4 en back", ch_en, 2'b11);
  endtask

  task automatic t_global();
    cfg_global = 1'b1;
    d_nostr[1] = 1'b1; step(); d_nostr[1] = 1'b0; step();
    check("R3 strike bit", latch_stat, 8'h40);
    check("R5 all off", ch_en, 2'b00);
    hclr();
    check("R5 all on", ch_en, 2'b11);
    cfg_global = 1'b0;
  endtask

  task automatic t_clear_while_active();
    d_open[0] = 1'b1; d_ovolt[0] = 1'b1; step(); d_open[0] = 1'b0; step();
    check("R3 two bits", latch_stat, 8'h09);
    host_clr = 1'b1; step(); host_clr = 1'b0;
    check("R7 active bit kept", latch_stat, 8'h08);
    d_ovolt[0] = 1'b0; step(3);
    check("R7 still stored", latch_stat, 8'h08);
    check("R2 live tracks input", live_stat, 8'h00);
    hclr();
    check("R7 final clear", latch_stat, 8'h00);
  endtask

  task automatic t_no_retry_when_off();
    cfg_retry = 1'b0;
    d_open[1] = 1'b1; step(); d_open[1] = 1'b0;
    ticks(6);
    check("R11 ticks ignored", latch_stat, 8'h10);
    check("R11 ch1 off", ch_en, 2'b01);
    hclr();
  endtask

  task automatic t_retry();
    cfg_retry = 1'b1;
    d_open[1] = 1'b1; step(); d_open[1] = 1'b0;
    ticks(3);
    check("R8 before last tick", latch_stat, 8'h10);
    dim_tick = 1'b1; step(); dim_tick = 1'b0;
    check("R8 cleared on last tick", latch_stat, 8'h00);
    step(2);
    check("R8 ch1 re-enabled", ch_en, 2'b11);
    check("R8 fault low", fault_o, 0);
    hclr();
  endtask

  task automatic t_ocur();
    cfg_retry = 1'b1;
    d_ocur[0] = 1'b1; d_open[0] = 1'b1; step(); d_ocur[0] = 1'b0; d_open[0] = 1'b0;
    ticks(12);
    check("R9 ocur kept", latch_stat, 8'h03);
    check("R9 ch0 off", ch_en, 2'b10);
    hclr();
    check("R9 host clears", latch_stat, 8'h00);
  endtask

  task automatic t_give_up();
    cfg_retry = 1'b1;
    for (int a = 0; a < 8; a++) begin
      d_nostr[0] = 1'b1; step(); d_nostr[0] = 1'b0;
      ticks(4);
      check("R10 retry within budget", latch_stat, 8'h00);
    end
    d_nostr[0] = 1'b1; step(); d_nostr[0] = 1'b0;
    ticks(12);
    check("R10 budget spent", latch_stat, 8'h04);
    hclr();
    d_nostr[0] = 1'b1; step(); d_nostr[0] = 1'b0;
    ticks(4);
    check("R10 budget restored", latch_stat, 8'h00);
    cfg_retry = 1'b0;
  endtask

  initial begin
    t_reset();
    t_local_and_clear();
    t_global();
    t_clear_while_active();
    t_no_retry_when_off();
    t_retry();
    t_ocur();
    t_give_up();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule